// File: doc/BRIEF.md
# Thread Context Ring CAM Matcher

This block decides which privilege ring of one hardware thread's interrupt context, if any, claims an incoming notification. A notification names a target as a block number and an index; together they form a 24-bit CAM value. The thread holds one context word per ring: physical, pool, OS and user. The block compares the target against these words and reports a hit flag and a two-bit ring code one clock after the inputs are presented.

There are two notification formats. Format 0 addresses a specific context. The physical ring, then the pool ring, then the OS ring are tried, and the first valid ring whose identity equals the target wins. The physical ring does not use a stored CAM field. Its identity is a line built from the chip block id and the thread id. Format 1 addresses a user-level handler. It hits only when the OS context owns the target and the user context carries the requested logical-server number. A format 0 notification with the ignore flag set asks for group matching, which this block does not support, so it always misses.

Top module: `tctx_ring_matcher`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hit` and `ring` are cleared to 0 on that edge, whatever the other inputs are.
- R2: `hit` and `ring` are registered. They reflect the inputs sampled at the previous rising edge and do not change between edges.
- R3: When `fmt` is 0 and `ign` is 1, `hit` is 0.
- R4: With `tid_8b` = 0, the hardware line is `{chip_blk, idx}`, where idx has bit 7 set, holds `thread_id[6:0]` in bits 6..0, and is zero elsewhere. Thread-id bit 7 is dropped. A format 0 target that equals this line, with `phys_w2[31]` set, gives `ring` = 3. The CAM field bits 23..0 of `phys_w2` are not used.
- R5: With `tid_8b` = 1, idx has bit 8 set and holds `thread_id[7:0]` in bits 7..0. Otherwise the physical match works as in R4.
- R6: For format 0, a pool word with bit 31 set whose bits 23..0 equal the target gives `ring` = 2. If bit 31 is clear, the pool word cannot match.
- R7: For format 0, an OS word with bit 31 set whose bits 23..0 equal the target gives `ring` = 1.
- R8: When several rings match in format 0, the priority is physical over pool over OS.
- R9: For format 1, `ring` = 0 with `hit` = 1 only if all of the following hold: `os_w2[31]` is set, `os_w2[23:0]` equals the target, `user_w2[31]` is set, and `user_w2[23:0]` equals `ls_num`. No other ring can be reported in format 1.
- R10: When no ring matches, `hit` is 0 and `ring` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_blk | input | 4 | Target block number (upper CAM bits) |
| tgt_idx | input | 20 | Target index (lower CAM bits) |
| fmt | input | 1 | Notification format: 0 specific context, 1 user level |
| ign | input | 1 | Group-match request (unsupported, forces a miss in format 0) |
| ls_num | input | 24 | Requested logical-server number (format 1) |
| phys_w2 | input | 32 | Physical ring word: bit 31 valid |
| pool_w2 | input | 32 | Pool ring word: bit 31 valid, bits 23..0 CAM |
| os_w2 | input | 32 | OS ring word: bit 31 valid, bits 23..0 CAM |
| user_w2 | input | 32 | User ring word: bit 31 valid, bits 23..0 logical server |
| chip_blk | input | 4 | Chip block id used in the hardware line |
| thread_id | input | 8 | Hardware thread id |
| tid_8b | input | 1 | Thread-id width select: 0 seven bits, 1 eight bits |
| hit | output | 1 | A ring matched |
| ring | output | 2 | Ring code: 0 user, 1 OS, 2 pool, 3 physical |

## Verification
The only state in the block is the output register. Any fault in it, or in the match logic ahead of it, shows up at `hit` and `ring` on the first edge after the offending input pattern. Typical faults are a wrong priority, a lost valid bit, or a misplaced marker bit. The vectors therefore pair each ring with a near-miss pattern: an invalid bit, a marker at the other width, a different chip id, or a format 1 request whose OS ring does not own the target. A fault is reported within one cycle of the vector that exposes it.

// File: rtl/tctx_ring_pkg.sv
// Package: shared ring codes and default field geometry for the matcher.
// Assumes a 32-bit context word with the valid flag in the top bit.
package tctx_ring_pkg;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_code_e;

    localparam int WORD_BITS  = 32;
    localparam int VALID_FLAG = 31;

endpackage

// File: rtl/tctx_hw_cam_line.sv
// Module: builds the physical ring's hardware CAM line from the chip block
// id and thread id. A marker bit sits just above the thread-id field, whose
// width is selected by tid_wide. Assumes IDX_W > TID_W.
module tctx_hw_cam_line #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 20,
    parameter int TID_W = 8
) (
    input  logic [BLK_W-1:0]       chip_blk,
    input  logic [TID_W-1:0]       thread_id,
    input  logic                   tid_wide,
    output logic [BLK_W+IDX_W-1:0] cam_line
);
    localparam int NARROW_W = TID_W - 1;

    logic [IDX_W-1:0] idx_wide;
    logic [IDX_W-1:0] idx_narrow;

    // Index part for full-width thread ids: marker at bit TID_W.
    always_comb begin
        idx_wide            = '0;
        idx_wide[TID_W-1:0] = thread_id;
        idx_wide[TID_W]     = 1'b1;
    end

    // Index part for narrow thread ids: top id bit dropped, marker one lower.
    always_comb begin
        idx_narrow               = '0;
        idx_narrow[NARROW_W-1:0] = thread_id[NARROW_W-1:0];
        idx_narrow[NARROW_W]     = 1'b1;
    end

    // Block id in the upper bits, selected index part below.
    assign cam_line = {chip_blk, (tid_wide ? idx_wide : idx_narrow)};

endmodule

// File: rtl/tctx_word_cmp.sv
// Module: checks one ring context word. It hits when the valid flag is set
// and the right-aligned field equals the reference. Assumes FIELD_W is
// less than VALID_POS.
module tctx_word_cmp #(
    parameter int WORD_W    = 32,
    parameter int FIELD_W   = 24,
    parameter int VALID_POS = 31
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [FIELD_W-1:0] ref_val,
    output logic               hit
);
    // Valid flag and field equality together.
    assign hit = word[VALID_POS] && (word[FIELD_W-1:0] == ref_val);

endmodule

// File: rtl/tctx_ring_select.sv
// Module: turns the per-ring hit flags into one result. Format 0 uses a
// fixed priority (physical, pool, OS) unless the group flag is set. Format 1
// only considers the combined OS-and-user hit.
module tctx_ring_select
    import tctx_ring_pkg::*;
(
    input  logic       fmt,
    input  logic       ign,
    input  logic       phys_hit,
    input  logic       pool_hit,
    input  logic       os_hit,
    input  logic       user_hit,
    output logic       any_hit,
    output ring_code_e code
);
    // Priority resolution per format; a miss reports the user code 0.
    always_comb begin
        any_hit = 1'b0;
        code    = RING_USER;
        if (fmt) begin
            if (os_hit && user_hit) begin
                any_hit = 1'b1;
                code    = RING_USER;
            end
        end else if (!ign) begin
            if (phys_hit) begin
                any_hit = 1'b1;
                code    = RING_PHYS;
            end else if (pool_hit) begin
                any_hit = 1'b1;
                code    = RING_POOL;
            end else if (os_hit) begin
                any_hit = 1'b1;
                code    = RING_OS;
            end
        end
    end

endmodule

// File: rtl/tctx_ring_matcher.sv
// Module: top of the thread-context ring matcher. It forms the target CAM
// value, compares it against the four ring words, resolves priority and
// registers the result. Synchronous active-low reset. Inputs are assumed
// stable around the rising edge.
module tctx_ring_matcher
    import tctx_ring_pkg::*;
#(
    parameter int BLK_W = 4,
    parameter int IDX_W = 20,
    parameter int TID_W = 8,
    parameter int LS_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BLK_W-1:0]     tgt_blk,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  logic                 fmt,
    input  logic                 ign,
    input  logic [LS_W-1:0]      ls_num,
    input  logic [WORD_BITS-1:0] phys_w2,
    input  logic [WORD_BITS-1:0] pool_w2,
    input  logic [WORD_BITS-1:0] os_w2,
    input  logic [WORD_BITS-1:0] user_w2,
    input  logic [BLK_W-1:0]     chip_blk,
    input  logic [TID_W-1:0]     thread_id,
    input  logic                 tid_8b,
    output logic                 hit,
    output logic [1:0]           ring
);
    localparam int CAM_W = BLK_W + IDX_W;
    localparam int N_CAM = 2;

    logic [CAM_W-1:0]     tgt_cam;
    logic [CAM_W-1:0]     hw_line;
    logic                 phys_hit;
    logic                 user_hit;
    logic [WORD_BITS-1:0] cam_word [N_CAM];
    logic [N_CAM-1:0]     cam_hit;
    logic                 sel_hit;
    ring_code_e           sel_code;

    // Target CAM value: block in the upper bits, index below.
    assign tgt_cam = {tgt_blk, tgt_idx};

    tctx_hw_cam_line #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W)) u_hw_line (
        .chip_blk (chip_blk),
        .thread_id(thread_id),
        .tid_wide (tid_8b),
        .cam_line (hw_line)
    );

    // Physical ring: valid flag plus the generated hardware line.
    assign phys_hit = phys_w2[VALID_FLAG] && (tgt_cam == hw_line);

    // Pool (slot 0) and OS (slot 1) words share one comparator shape.
    assign cam_word[0] = pool_w2;
    assign cam_word[1] = os_w2;

    for (genvar g = 0; g < N_CAM; g++) begin : g_cam_cmp
        tctx_word_cmp #(.WORD_W(WORD_BITS), .FIELD_W(CAM_W), .VALID_POS(VALID_FLAG)) u_cmp (
            .word   (cam_word[g]),
            .ref_val(tgt_cam),
            .hit    (cam_hit[g])
        );
    end

    tctx_word_cmp #(.WORD_W(WORD_BITS), .FIELD_W(LS_W), .VALID_POS(VALID_FLAG)) u_user_cmp (
        .word   (user_w2),
        .ref_val(ls_num),
        .hit    (user_hit)
    );

    tctx_ring_select u_select (
        .fmt     (fmt),
        .ign     (ign),
        .phys_hit(phys_hit),
        .pool_hit(cam_hit[0]),
        .os_hit  (cam_hit[1]),
        .user_hit(user_hit),
        .any_hit (sel_hit),
        .code    (sel_code)
    );

    // Output register holding the resolved match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            ring <= 2'd0;
        end else begin
            hit  <= sel_hit;
            ring <= sel_code;
        end
    end

    // R3: a group request in format 0 never produces a hit.
    a_r3_ignore_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt && ign) |=> !hit);

    // R9: format 1 cannot hit unless the OS context is valid.
    a_r9_user_needs_os: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt && !os_w2[VALID_FLAG]) |=> !hit);

    // R9: format 1 can only report the user ring.
    a_r9_user_code_only: assert property (@(posedge clk) disable iff (!rst_n)
        fmt |=> (!hit || ring == 2'd0));

    // R10: a miss always carries ring code 0.
    a_r10_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ring == 2'd0);

    // R6: with every format 0 valid flag clear, nothing can hit.
    a_r6_no_valid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt && !phys_w2[VALID_FLAG] && !pool_w2[VALID_FLAG] && !os_w2[VALID_FLAG]) |=> !hit);

    // R1: the first edge out of reset shows the cleared outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (!hit && ring == 2'd0));

endmodule

// File: tb/test_tctx_ring_matcher.sv
// Bench for tctx_ring_matcher: a vector table walked by one loop, then
// directed checks for reset and latency.
module test_tctx_ring_matcher;

    typedef struct packed {
        logic        fmt;
        logic        ign;
        logic        t8;
        logic [3:0]  chip;
        logic [7:0]  tid;
        logic [23:0] tgt;
        logic [23:0] ls;
        logic [31:0] phys;
        logic [31:0] pool;
        logic [31:0] os;
        logic [31:0] user;
        logic        ehit;
        logic [1:0]  ering;
    } vec_t;

    localparam int NV = 15;
    // Hardware line for chip 3, thread A5: 7-bit 3000A5, 8-bit 3001A5.
    localparam vec_t VECS [NV] = '{
        // R4: physical hit in 7-bit mode, CAM field of phys word unused
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h0, 32'h80FFFFFF, 32'h0, 32'h0, 32'h0, 1'b1, 2'd3},
        // R5: physical hit in 8-bit mode
        '{1'b0, 1'b0, 1'b1, 4'h3, 8'hA5, 24'h3001A5, 24'h0, 32'h80000000, 32'h0, 32'h0, 32'h0, 1'b1, 2'd3},
        // R4: 8-bit line offered in 7-bit mode misses
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3001A5, 24'h0, 32'h80000000, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0},
        // R4: other chip id misses
        '{1'b0, 1'b0, 1'b0, 4'h2, 8'hA5, 24'h3000A5, 24'h0, 32'h80000000, 32'h0, 32'h0, 32'h0, 1'b0, 2'd0},
        // R6: pool hit
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h123456, 24'h0, 32'h0, 32'h80123456, 32'h0, 32'h0, 1'b1, 2'd2},
        // R7: OS hit
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'hABCDEF, 24'h0, 32'h0, 32'h0, 32'h80ABCDEF, 32'h0, 1'b1, 2'd1},
        // R8: all three match, physical wins
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h0, 32'h80000000, 32'h803000A5, 32'h803000A5, 32'h0, 1'b1, 2'd3},
        // R8: pool beats OS when physical is invalid
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h0, 32'h00000000, 32'h803000A5, 32'h803000A5, 32'h0, 1'b1, 2'd2},
        // R6: invalid pool word falls through to OS
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h123456, 24'h0, 32'h0, 32'h00123456, 32'h80123456, 32'h0, 1'b1, 2'd1},
        // R3: group request with every ring matching misses
        '{1'b0, 1'b1, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h0, 32'h80000000, 32'h803000A5, 32'h803000A5, 32'h0, 1'b0, 2'd0},
        // R9: user hit
        '{1'b1, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h555555, 24'h000042, 32'h0, 32'h0, 32'h80555555, 32'h80000042, 1'b1, 2'd0},
        // R9: logical-server mismatch misses
        '{1'b1, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h555555, 24'h000043, 32'h0, 32'h0, 32'h80555555, 32'h80000042, 1'b0, 2'd0},
        // R9: OS word invalid misses
        '{1'b1, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h555555, 24'h000042, 32'h0, 32'h0, 32'h00555555, 32'h80000042, 1'b0, 2'd0},
        // R9: format 1 with physical and OS matching but user invalid misses
        '{1'b1, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h000000, 32'h80000000, 32'h803000A5, 32'h803000A5, 32'h00000000, 1'b0, 2'd0},
        // R10: nothing valid misses
        '{1'b0, 1'b0, 1'b0, 4'h3, 8'hA5, 24'h3000A5, 24'h0, 32'h0, 32'h003000A5, 32'h003000A5, 32'h0, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tgt_blk = '0;
    logic [19:0] tgt_idx = '0;
    logic        fmt = 1'b0;
    logic        ign = 1'b0;
    logic [23:0] ls_num = '0;
    logic [31:0] phys_w2 = '0;
    logic [31:0] pool_w2 = '0;
    logic [31:0] os_w2 = '0;
    logic [31:0] user_w2 = '0;
    logic [3:0]  chip_blk = '0;
    logic [7:0]  thread_id = '0;
    logic        tid_8b = 1'b0;
    logic        hit;
    logic [1:0]  ring;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tctx_ring_matcher i_tctx_ring_matcher (
        .clk(clk), .rst_n(rst_n), .tgt_blk(tgt_blk), .tgt_idx(tgt_idx),
        .fmt(fmt), .ign(ign), .ls_num(ls_num), .phys_w2(phys_w2),
        .pool_w2(pool_w2), .os_w2(os_w2), .user_w2(user_w2),
        .chip_blk(chip_blk), .thread_id(thread_id), .tid_8b(tid_8b),
        .hit(hit), .ring(ring)
    );

    task automatic apply(input vec_t v);
        fmt = v.fmt; ign = v.ign; tid_8b = v.t8; chip_blk = v.chip;
        thread_id = v.tid; {tgt_blk, tgt_idx} = v.tgt; ls_num = v.ls;
        phys_w2 = v.phys; pool_w2 = v.pool; os_w2 = v.os; user_w2 = v.user;
    endtask

    task automatic check(input string req, input logic eh, input logic [1:0] er);
        n_checks++;
        if (hit !== eh || ring !== er) begin
            n_fail++;
            $display("FAIL %s: hit=%0b ring=%0d expected hit=%0b ring=%0d", req, hit, ring, eh, er);
        end
    endtask

    initial begin
        // R1: matching inputs held during reset must not show a hit
        apply(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset clear", 1'b0, 2'd0);
        rst_n = 1'b1;

        // Vector table: drive at negedge, result visible after next posedge
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vector %0d", i), VECS[i].ehit, VECS[i].ering);
        end

        // R2: a new input changes nothing before the next edge
        apply(VECS[4]);
        @(posedge clk);
        @(negedge clk);
        apply(VECS[5]);
        #2;
        check("R2 held until edge", 1'b1, 2'd2);
        @(posedge clk);
        @(negedge clk);
        check("R2 updated after edge", 1'b1, 2'd1);

        // R1: reset asserted mid-run clears a standing hit on the next edge
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", 1'b0, 2'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 after reset release", 1'b1, 2'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule